// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block chooses the fetch address each cycle for a simple in-order five-stage pipeline. The architecture exposes a single branch delay slot. A branch is resolved while it sits in decode. By then only one younger instruction has been fetched: the one in the delay slot. The block compares two register operands for equality or inequality and decides the branch direction. On a taken branch it steers fetch to a target address that decode has already computed. With no taken branch, fetch simply walks forward by one word, which is a static not-taken policy.

Ordinary branches let the delay-slot instruction execute in both directions. A second family, the "likely" branches, keeps the slot instruction only when the branch is taken. When a likely branch falls through, the block raises a one-cycle annul flag so that the slot instruction is squashed. A stall input freezes the fetch address and suppresses any redirect or annul decision. The register file, the interlocks and the instruction memory lie outside this block.

Top module: `delayed_fetch_seq`

## Requirements
- R1: While `rstN` is low and after its release, `fetchPc` equals `RESET_PC` (default 0x0000_1000) and `slotAnnul` is 0 until the first clock edge with reset released.
- R2: With `stall` low and `brValid` low, `fetchPc` grows by `STEP` (4) at every clock edge.
- R3: An ordinary branch redirects fetch when it is taken. Encodings: `brKind` = 2'b00 is taken when `opA == opB`, and 2'b01 is taken when `opA != opB`. On the edge that ends the branch's decode cycle, `fetchPc` loads `brTarget`, so the slot instruction already fetched still executes, and `slotAnnul` stays 0.
- R4: An ordinary branch (`brKind` 2'b00 or 2'b01) that is not taken leaves fetch sequential (`fetchPc` + 4) with `slotAnnul` 0.
- R5: A likely branch that is taken redirects fetch in the same way as R3, with `slotAnnul` 0. Encodings: `brKind` = 2'b10 is taken when the operands are equal, and 2'b11 is taken when they differ (bit 1 marks likely, bit 0 inverts the test).
- R6: A likely branch that is not taken leaves fetch sequential. `slotAnnul` is then 1 for exactly the one cycle after the branch's decode cycle.
- R7: While `stall` is high, `fetchPc` holds its value, and a branch presented in that cycle neither redirects fetch nor raises `slotAnnul`.
- R8: `nextPc` always equals the value that `fetchPc` takes on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Freeze fetch and ignore the decode branch this cycle |
| brValid | input | 1 | Decode holds a conditional branch |
| brKind | input | 2 | Bit 1: likely variant; bit 0: taken on not-equal |
| opA | input | DATA_W | First register operand of the branch |
| opB | input | DATA_W | Second register operand of the branch |
| brTarget | input | PC_W | Branch target precomputed by decode |
| fetchPc | output | PC_W | Address being fetched this cycle |
| nextPc | output | PC_W | Address to be fetched next cycle |
| slotAnnul | output | 1 | Squash the delay-slot instruction now entering decode |

## Verification
The assertions assume that decode never presents a branch in two back-to-back unstalled cycles, because a branch cannot itself sit in a delay slot. Under that assumption an annul pulse can never be extended by a second likely branch. The stimulus always puts at least one idle or stalled cycle after each branch, and it covers both compare senses in both the ordinary and the likely families. A branch is also offered during a stall, to show that it is ignored until the stall is released.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    BR_EQ        = 2'b00,
    BR_NE        = 2'b01,
    BR_EQ_LIKELY = 2'b10,
    BR_NE_LIKELY = 2'b11
  } brKind_e;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic hold;        // keep current fetch address
    logic loadTarget;  // steer fetch to the branch target
    logic annulSlot;   // squash the instruction now in fetch
  } seqStrobe_t;

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              stall,
  input  logic              brValid,
  input  brKind_e           brKind,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output seqStrobe_t        strobe
);

  logic opsEqual;
  logic wantNe;
  logic isLikely;
  logic taken;

  always_comb begin
    opsEqual = (opA == opB);
    wantNe   = brKind[0];
    isLikely = brKind[1];
    taken    = brValid && (opsEqual ^ wantNe);

    strobe.hold       = stall;
    strobe.loadTarget = !stall && taken;
    strobe.annulSlot  = !stall && brValid && isLikely && !taken;
  end

endmodule

// File: rtl/fseq_datapath.sv
module fseq_datapath
  import fseq_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_1000,
  parameter int              STEP     = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      strobe,
  input  logic [PC_W-1:0] brTarget,
  output logic [PC_W-1:0] fetchPc,
  output logic [PC_W-1:0] nextPc,
  output logic            slotAnnul
);

  localparam logic [PC_W-1:0] StepVal = PC_W'(STEP);

  logic [PC_W-1:0] seqPc;

  always_comb begin
    seqPc = fetchPc + StepVal;
    if (strobe.hold)
      nextPc = fetchPc;
    else if (strobe.loadTarget)
      nextPc = brTarget;
    else
      nextPc = seqPc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchPc   <= RESET_PC;
      slotAnnul <= 1'b0;
    end else begin
      fetchPc   <= nextPc;
      slotAnnul <= strobe.annulSlot;
    end
  end

endmodule

// File: rtl/delayed_fetch_seq.sv
module delayed_fetch_seq
  import fseq_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              DATA_W   = 32,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_1000,
  parameter int              STEP     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic              brValid,
  input  logic [1:0]        brKind,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [PC_W-1:0]   brTarget,
  output logic [PC_W-1:0]   fetchPc,
  output logic [PC_W-1:0]   nextPc,
  output logic              slotAnnul
);

  seqStrobe_t strobe;

  fseq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .stall   (stall),
    .brValid (brValid),
    .brKind  (brKind_e'(brKind)),
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe)
  );

  fseq_datapath #(.PC_W(PC_W), .RESET_PC(RESET_PC), .STEP(STEP)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .brTarget  (brTarget),
    .fetchPc   (fetchPc),
    .nextPc    (nextPc),
    .slotAnnul (slotAnnul)
  );

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              stall,
  input logic              brValid,
  input logic [1:0]        brKind,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [PC_W-1:0]   brTarget,
  input logic [PC_W-1:0]   fetchPc,
  input logic [PC_W-1:0]   nextPc,
  input logic              slotAnnul
);

  logic isTaken;
  assign isTaken = brValid && ((opA == opB) ^ brKind[0]);

  a_r2_sequential: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !brValid) |=> fetchPc == $past(fetchPc) + PC_W'(STEP));

  a_r3_taken_redirect: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && isTaken) |=> (fetchPc == $past(brTarget)) && !slotAnnul);

  a_r4_ordinary_no_annul: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && brValid && !brKind[1]) |=> !slotAnnul);

  a_r6_annul_cause: assert property (@(posedge clk) disable iff (!rstN)
    slotAnnul |-> $past(!stall && brValid && brKind[1] && !isTaken));

  a_r6_annul_single: assert property (@(posedge clk) disable iff (!rstN)
    slotAnnul |=> !slotAnnul);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(fetchPc) && !slotAnnul);

  a_r8_next_matches: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> fetchPc == $past(nextPc));

endmodule

bind delayed_fetch_seq fseq_checker #(.PC_W(PC_W), .DATA_W(DATA_W), .STEP(STEP)) u_chk (
  .clk(clk), .rstN(rstN), .stall(stall), .brValid(brValid), .brKind(brKind),
  .opA(opA), .opB(opB), .brTarget(brTarget), .fetchPc(fetchPc),
  .nextPc(nextPc), .slotAnnul(slotAnnul)
);

// File: tb/test_delayed_fetch_seq.sv
module test_delayed_fetch_seq;

  localparam int          PC_W  = 32;
  localparam int          DW    = 32;
  localparam logic [31:0] RSTPC = 32'h0000_1000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            stall = 1'b0;
  logic            brValid = 1'b0;
  logic [1:0]      brKind = 2'b00;
  logic [DW-1:0]   opA = '0;
  logic [DW-1:0]   opB = '0;
  logic [PC_W-1:0] brTarget = '0;
  logic [PC_W-1:0] fetchPc;
  logic [PC_W-1:0] nextPc;
  logic            slotAnnul;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mPc;
  logic [32:0] expQ[$];
  string       tagQ[$];
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  delayed_fetch_seq #(.PC_W(PC_W), .DATA_W(DW), .RESET_PC(RSTPC), .STEP(4)) i_delayed_fetch_seq (
    .clk(clk), .rstN(rstN), .stall(stall), .brValid(brValid), .brKind(brKind),
    .opA(opA), .opB(opB), .brTarget(brTarget), .fetchPc(fetchPc),
    .nextPc(nextPc), .slotAnnul(slotAnnul)
  );

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%09h expected 0x%09h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input logic v, input logic [1:0] k, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] tgt,
                      input logic st, input string tag);
    logic taken;
    logic [31:0] nPc;
    logic ann;
    @(negedge clk);
    brValid = v; brKind = k; opA = a; opB = b; brTarget = tgt; stall = st;
    taken = v && ((a == b) != k[0]);
    ann = 1'b0;
    if (st) nPc = mPc;
    else if (taken) nPc = tgt;
    else begin
      nPc = mPc + 32'd4;
      ann = v && k[1];
    end
    #1;
    check("R8 nextPc", {1'b0, nextPc}, {1'b0, nPc});
    expQ.push_back({ann, nPc});
    tagQ.push_back(tag);
    mPc = nPc;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 2'b00, 32'd0, 32'd0, 32'd0, 1'b0, tag);
  endtask

  // Monitor: compares outputs just after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [32:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {slotAnnul, fetchPc}, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", {slotAnnul, fetchPc}, {1'b0, RSTPC});
    rstN = 1'b1;
    mPc = RSTPC;
    @(posedge clk);
    #1;
    check("R1 after release", {slotAnnul, fetchPc}, {1'b0, RSTPC + 32'd4});
    mPc = RSTPC + 32'd4;

    idle("R2 sequential");
    idle("R2 sequential");
    idle("R2 sequential");
    // ordinary taken: eq/equal and ne/unequal
    step(1'b1, 2'b00, 32'h55, 32'h55, 32'h0000_2000, 1'b0, "R3 eq taken");
    idle("R3 after eq taken");
    step(1'b1, 2'b01, 32'h10, 32'h11, 32'h0000_3000, 1'b0, "R3 ne taken");
    idle("R3 after ne taken");
    // ordinary not taken
    step(1'b1, 2'b00, 32'h10, 32'h11, 32'h0000_9000, 1'b0, "R4 eq not taken");
    idle("R4 after eq not taken");
    step(1'b1, 2'b01, 32'h77, 32'h77, 32'h0000_9000, 1'b0, "R4 ne not taken");
    idle("R4 after ne not taken");
    // likely taken
    step(1'b1, 2'b10, 32'hA, 32'hA, 32'h0000_4000, 1'b0, "R5 eq-likely taken");
    idle("R5 after");
    step(1'b1, 2'b11, 32'hA, 32'hB, 32'h0000_5000, 1'b0, "R5 ne-likely taken");
    idle("R5 after");
    // likely not taken: annul for exactly one cycle
    step(1'b1, 2'b10, 32'h1, 32'h2, 32'h0000_9000, 1'b0, "R6 eq-likely annul");
    idle("R6 annul single cycle");
    idle("R6 annul stays low");
    step(1'b1, 2'b11, 32'h3, 32'h3, 32'h0000_9000, 1'b0, "R6 ne-likely annul");
    idle("R6 annul single cycle");
    // stall holds and ignores branches
    step(1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 1'b1, "R7 stall hold");
    step(1'b1, 2'b00, 32'h4, 32'h4, 32'h0000_6000, 1'b1, "R7 stall blocks redirect");
    step(1'b1, 2'b10, 32'h4, 32'h5, 32'h0000_6000, 1'b1, "R7 stall blocks annul");
    idle("R7 resume sequential");
    step(1'b1, 2'b01, 32'h4, 32'h5, 32'h0000_7000, 1'b0, "R3 taken after stall");
    idle("R2 sequential after target");

    @(negedge clk);
    brValid = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule